// File: doc/BRIEF.md
# Programmable LVDS Bit Mux and Serializer

This block turns one parallel pixel (8-bit red, green and blue plus horizontal sync, vertical sync and data enable) into the serial streams of a four-lane LVDS transmitter. Every one of the 28 bit slots of a pixel period picks its source through its own 5-bit select code held in a small register file. The same hardware can therefore produce the VESA layout, the JEIDA layout or any other arrangement, and software sets the layout by writing the select words.

After the mux, a 7:1 shift serializer sends seven slots per lane on four data lanes, along with a clock lane that repeats a fixed 7-bit pattern. The block runs on the bit clock. A bit-clock enable advances the serializer, and a new pixel is sampled on every seventh enabled edge. A single link is specified for pixel clocks up to 135 MHz and a dual link up to 270 MHz, so the bit clock runs at seven times the pixel rate. The analog drivers, the PLL and the splitting of pixels across two links are outside this block.

Top module: `lvds_bitmux_tx`

## Requirements
- R1: After reset, the select words hold the VESA layout: slots 0..27 take codes 0,1,2,3,4,7,5,8,9,10,14,15,11,12,13,16,22,23,17,18,19,20,21,27,24,25,26,6. In that layout, slot 23 carries code 27, and the sync and enable codes are in slots 24..26. Also after reset, all data lanes and the clock lane output 0.
- R2: The source codes are: red bit i = i, green bit i = 8+i, blue bit i = 16+i, HS = 24, VS = 25, DE = 26.
- R3: Select word w (address 0..6) holds the selects of slots 4w..4w+3 in bits 4:0, 12:8, 20:16 and 28:24, in that slot order. A read returns these fields, and every other bit reads as 0.
- R4: A write to address 7 changes no select, and a read of address 7 returns 0.
- R5: Codes 27 to 31 drive a constant 0 into their slot.
- R6: Slot k travels on data lane k/7 at position k mod 7. Position 0 appears on the enabled edge that samples the pixel, and positions 1..6 appear on the following six enabled edges.
- R7: The clock lane sends 1,1,0,0,0,1,1 over positions 0..6 of every pixel period.
- R8: While bit_en is low, the lane outputs and the bit position hold their values.
- R9: The first enabled edge after reset samples a pixel, and so does every seventh enabled edge after that. pix_load is high exactly when the next edge is such a sampling edge (bit_en high and the position at 6).
- R10: A select write takes effect at the next pixel sample. Bits of a pixel that has already been sampled are not changed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bit-clock enable; one serial step per enabled edge |
| cfg_we | input | 1 | Select word write strobe |
| cfg_addr | input | 3 | Select word address |
| cfg_wdata | input | 32 | Select word write data |
| cfg_rdata | output | 32 | Select word read data for cfg_addr |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| pix_load | output | 1 | Next edge samples the pixel inputs |
| lane_data | output | 4 | Serial data lanes |
| lane_clk | output | 1 | Serial clock lane |

## Verification
The assertions assume that the pixel inputs are stable around any edge where pix_load is high. They also assume that bit_en and the configuration port change only away from the clock edge, so the hold and cadence properties see clean, single-edge behaviour. The bench drives every input on the falling edge. Before it changes the pixel, it waits for pix_load, and it stops bit_en right after a full period so that writes land while the serializer is paused. The only exception is the in-flight write case, which deliberately lands a write during a running period.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

   localparam int LAYOUT_VESA  = 0;
   localparam int LAYOUT_JEIDA = 1;

   // Reset select code for one slot under a standard layout.
   // cw is the colour width; codes follow the source enumeration.
   function automatic int layout_code(int layout, int slot, int cw);
      int r, g, b, hs, vs, de, lo;
      int c;
      r  = 0;
      g  = cw;
      b  = 2 * cw;
      hs = 3 * cw;
      vs = 3 * cw + 1;
      de = 3 * cw + 2;
      lo = 3 * cw + 3;
      c  = lo;
      if (layout == LAYOUT_JEIDA) begin
         case (slot)
            0:  c = r + 2;   1:  c = r + 3;   2:  c = r + 4;   3:  c = r + 5;
            4:  c = r + 6;   5:  c = r + 1;   6:  c = r + 7;   7:  c = g + 2;
            8:  c = g + 3;   9:  c = g + 4;   10: c = g + 0;   11: c = g + 1;
            12: c = g + 5;   13: c = g + 6;   14: c = g + 7;   15: c = b + 2;
            16: c = b + 0;   17: c = b + 1;   18: c = b + 3;   19: c = b + 4;
            20: c = b + 5;   21: c = b + 6;   22: c = b + 7;   23: c = lo;
            24: c = hs;      25: c = vs;      26: c = de;      27: c = r + 0;
            default: c = lo;
         endcase
      end else begin
         case (slot)
            0:  c = r + 0;   1:  c = r + 1;   2:  c = r + 2;   3:  c = r + 3;
            4:  c = r + 4;   5:  c = r + 7;   6:  c = r + 5;   7:  c = g + 0;
            8:  c = g + 1;   9:  c = g + 2;   10: c = g + 6;   11: c = g + 7;
            12: c = g + 3;   13: c = g + 4;   14: c = g + 5;   15: c = b + 0;
            16: c = b + 6;   17: c = b + 7;   18: c = b + 1;   19: c = b + 2;
            20: c = b + 3;   21: c = b + 4;   22: c = b + 5;   23: c = lo;
            24: c = hs;      25: c = vs;      26: c = de;      27: c = r + 6;
            default: c = lo;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/lbm_sel_regs.sv
module lbm_sel_regs #(
   parameter int SLOTS        = 28,
   parameter int SEL_W        = 5,
   parameter int CFG_W        = 32,
   parameter int FIELD_STRIDE = 8,
   parameter int COLOR_W      = 8,
   parameter int LAYOUT       = 0,
   localparam int PER_WORD    = CFG_W / FIELD_STRIDE,
   localparam int NUM_WORDS   = SLOTS / PER_WORD,
   localparam int ADDR_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS + 1) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [CFG_W-1:0]       wdata,
   output logic [CFG_W-1:0]       rdata,
   output logic [SLOTS*SEL_W-1:0] sel_flat
);

   generate
      if (SLOTS % PER_WORD != 0) begin : g_bad_slots
         $error("SLOTS must be a multiple of the selects per word");
      end
      if (SEL_W > FIELD_STRIDE) begin : g_bad_stride
         $error("select field wider than its stride");
      end
      if (CFG_W % FIELD_STRIDE != 0) begin : g_bad_cfgw
         $error("word width must be a multiple of the field stride");
      end
   endgenerate

   logic [SEL_W-1:0] sel_q [SLOTS];
   logic             addr_ok;

   assign addr_ok = ({1'b0, addr} < (ADDR_W + 1)'(NUM_WORDS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < SLOTS; k++) begin
            sel_q[k] <= SEL_W'(lbm_pkg::layout_code(LAYOUT, k, COLOR_W));
         end
      end else if (we && addr_ok) begin
         for (int f = 0; f < PER_WORD; f++) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
               if (addr == ADDR_W'(w)) begin
                  sel_q[w*PER_WORD+f] <= wdata[f*FIELD_STRIDE +: SEL_W];
               end
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (addr == ADDR_W'(w)) begin
            for (int f = 0; f < PER_WORD; f++) begin
               rdata[f*FIELD_STRIDE +: SEL_W] = sel_q[w*PER_WORD+f];
            end
         end
      end
   end

   genvar gk;
   generate
      for (gk = 0; gk < SLOTS; gk++) begin : g_flat
         assign sel_flat[gk*SEL_W +: SEL_W] = sel_q[gk];
      end
   endgenerate

   // R4: an out-of-range write leaves every select untouched
   assert_bad_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !addr_ok) |=> $stable(sel_flat));

   // R10: with no write strobe the selects do not move
   assert_no_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(sel_flat));

endmodule

// File: rtl/lbm_slot_mux.sv
module lbm_slot_mux #(
   parameter int SLOTS   = 28,
   parameter int SEL_W   = 5,
   parameter int COLOR_W = 8,
   localparam int NSRC      = 2 ** SEL_W,
   localparam int CODE_HS   = 3 * COLOR_W,
   localparam int CODE_VS   = 3 * COLOR_W + 1,
   localparam int CODE_DE   = 3 * COLOR_W + 2,
   localparam int CODE_LOW  = 3 * COLOR_W + 3
) (
   input  logic [COLOR_W-1:0]     r,
   input  logic [COLOR_W-1:0]     g,
   input  logic [COLOR_W-1:0]     b,
   input  logic                   hs,
   input  logic                   vs,
   input  logic                   de,
   input  logic [SLOTS*SEL_W-1:0] sel_flat,
   output logic [SLOTS-1:0]       slot_bits
);

   generate
      if (NSRC < CODE_LOW + 1) begin : g_bad_sel
         $error("select width too small for the source enumeration");
      end
   endgenerate

   logic [NSRC-1:0] src;

   always_comb begin
      src = '0;
      src[0*COLOR_W +: COLOR_W] = r;
      src[1*COLOR_W +: COLOR_W] = g;
      src[2*COLOR_W +: COLOR_W] = b;
      src[CODE_HS] = hs;
      src[CODE_VS] = vs;
      src[CODE_DE] = de;
   end

   genvar gk;
   generate
      for (gk = 0; gk < SLOTS; gk++) begin : g_slot
         logic [SEL_W-1:0] sel;
         assign sel           = sel_flat[gk*SEL_W +: SEL_W];
         assign slot_bits[gk] = src[sel];

         // R5: codes at and above the constant-low code give 0
         always_comb begin
            if (sel >= SEL_W'(CODE_LOW)) begin
               assert_const_low_R5: assert (slot_bits[gk] == 1'b0);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lbm_lane_ser.sv
module lbm_lane_ser #(
   parameter int LANES = 4,
   parameter int BITS  = 7,
   parameter logic [BITS-1:0] CLK_PATTERN = 7'b1100011,
   localparam int SLOTS = LANES * BITS,
   localparam int PH_W  = $clog2(BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic [SLOTS-1:0] slot_bits,
   output logic             load,
   output logic [LANES-1:0] lane_data,
   output logic             lane_clk
);

   generate
      if (BITS < 2) begin : g_bad_bits
         $error("serializer needs at least two bits per lane");
      end
   endgenerate

   localparam logic [PH_W-1:0] LAST = PH_W'(BITS - 1);

   logic [PH_W-1:0] ph_q;
   logic [BITS-1:0] ck_q;

   assign load = bit_en && (ph_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= LAST;
      end else if (bit_en) begin
         if (ph_q == LAST) ph_q <= '0;
         else              ph_q <= ph_q + 1'b1;
      end
   end

   genvar gl;
   generate
      for (gl = 0; gl < LANES; gl++) begin : g_lane
         logic [BITS-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sh_q <= '0;
            else if (load)   sh_q <= slot_bits[gl*BITS +: BITS];
            else if (bit_en) sh_q <= sh_q >> 1;
         end
         assign lane_data[gl] = sh_q[0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ck_q <= '0;
      else if (load)   ck_q <= CLK_PATTERN;
      else if (bit_en) ck_q <= ck_q >> 1;
   end
   assign lane_clk = ck_q[0];

   // R8: a paused enable freezes the outputs and the position
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(lane_data) && $stable(lane_clk) && $stable(ph_q)));

   // R7: the clock lane opens every pixel period with its first pattern bit
   assert_clk_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (lane_clk == CLK_PATTERN[0]));

   // R9: two sampling edges are never adjacent
   assert_cadence_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !load);

endmodule

// File: rtl/lvds_bitmux_tx.sv
module lvds_bitmux_tx #(
   parameter int LANES         = 4,
   parameter int BITS_PER_LANE = 7,
   parameter int COLOR_W       = 8,
   parameter int SEL_W         = 5,
   parameter int CFG_W         = 32,
   parameter int FIELD_STRIDE  = 8,
   parameter int RESET_LAYOUT  = lbm_pkg::LAYOUT_VESA,
   parameter logic [BITS_PER_LANE-1:0] CLK_PATTERN = 7'b1100011,
   localparam int SLOTS     = LANES * BITS_PER_LANE,
   localparam int PER_WORD  = CFG_W / FIELD_STRIDE,
   localparam int NUM_WORDS = SLOTS / PER_WORD,
   localparam int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS + 1) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_en,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [CFG_W-1:0]   cfg_wdata,
   output logic [CFG_W-1:0]   cfg_rdata,
   input  logic [COLOR_W-1:0] pix_r,
   input  logic [COLOR_W-1:0] pix_g,
   input  logic [COLOR_W-1:0] pix_b,
   input  logic               pix_hs,
   input  logic               pix_vs,
   input  logic               pix_de,
   output logic               pix_load,
   output logic [LANES-1:0]   lane_data,
   output logic               lane_clk
);

   generate
      if (RESET_LAYOUT != lbm_pkg::LAYOUT_VESA && RESET_LAYOUT != lbm_pkg::LAYOUT_JEIDA) begin : g_bad_layout
         $error("unknown reset layout");
      end
   endgenerate

   logic [SLOTS*SEL_W-1:0] sel_flat;
   logic [SLOTS-1:0]       slot_bits;

   lbm_sel_regs #(
      .SLOTS(SLOTS), .SEL_W(SEL_W), .CFG_W(CFG_W),
      .FIELD_STRIDE(FIELD_STRIDE), .COLOR_W(COLOR_W), .LAYOUT(RESET_LAYOUT)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .sel_flat(sel_flat)
   );

   lbm_slot_mux #(
      .SLOTS(SLOTS), .SEL_W(SEL_W), .COLOR_W(COLOR_W)
   ) i_mux (
      .r(pix_r), .g(pix_g), .b(pix_b), .hs(pix_hs), .vs(pix_vs), .de(pix_de),
      .sel_flat(sel_flat), .slot_bits(slot_bits)
   );

   lbm_lane_ser #(
      .LANES(LANES), .BITS(BITS_PER_LANE), .CLK_PATTERN(CLK_PATTERN)
   ) i_ser (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .slot_bits(slot_bits),
      .load(pix_load), .lane_data(lane_data), .lane_clk(lane_clk)
   );

endmodule

// File: tb/test_lvds_bitmux_tx.sv
module test_lvds_bitmux_tx;

   localparam int CLK_PERIOD = 10;
   localparam int NSLOT = 28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
   logic        pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
   logic        pix_load;
   logic [3:0]  lane_data;
   logic        lane_clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   int vesa_tab  [NSLOT] = '{0,1,2,3,4,7,5,8,9,10,14,15,11,12,13,16,22,23,17,18,19,20,21,27,24,25,26,6};
   int jeida_tab [NSLOT] = '{2,3,4,5,6,1,7,10,11,12,8,9,13,14,15,18,16,17,19,20,21,22,23,27,24,25,26,0};
   int exp_sel   [NSLOT];

   always #(CLK_PERIOD/2) clk = ~clk;

   lvds_bitmux_tx i_lvds_bitmux_tx (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
      .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
      .pix_load(pix_load), .lane_data(lane_data), .lane_clk(lane_clk)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic src_bit(int code, logic [7:0] r, logic [7:0] g, logic [7:0] b,
                                    logic hs, logic vs, logic de);
      if (code < 8)       return r[code];
      else if (code < 16) return g[code-8];
      else if (code < 24) return b[code-16];
      else if (code == 24) return hs;
      else if (code == 25) return vs;
      else if (code == 26) return de;
      return 1'b0;
   endfunction

   function automatic logic [27:0] exp_slots(logic [7:0] r, logic [7:0] g, logic [7:0] b,
                                             logic hs, logic vs, logic de);
      logic [27:0] v;
      for (int k = 0; k < NSLOT; k++) v[k] = src_bit(exp_sel[k], r, g, b, hs, vs, de);
      return v;
   endfunction

   function automatic logic [31:0] pack_word(int w);
      logic [31:0] v = '0;
      for (int f = 0; f < 4; f++) v[f*8 +: 5] = 5'(exp_sel[w*4+f]);
      return v;
   endfunction

   // slot k sits in got[(k/7)*7 + k%7] == got[k]
   task automatic send_pixel(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                             input logic hs, input logic vs, input logic de,
                             output logic [27:0] got, output logic [6:0] ckp);
      @(negedge clk);
      pix_r = r; pix_g = g; pix_b = b; pix_hs = hs; pix_vs = vs; pix_de = de;
      bit_en = 1'b1;
      #1;
      while (!pix_load) begin
         @(negedge clk); #1;
      end
      for (int p = 0; p < 7; p++) begin
         @(negedge clk); #1;
         for (int l = 0; l < 4; l++) got[l*7+p] = lane_data[l];
         ckp[p] = lane_clk;
      end
      bit_en = 1'b0;
   endtask

   task automatic pixel_check(input string tag, input logic [7:0] r, input logic [7:0] g,
                              input logic [7:0] b, input logic hs, input logic vs, input logic de);
      logic [27:0] got, exp;
      logic [6:0]  ckp;
      exp = exp_slots(r, g, b, hs, vs, de);
      send_pixel(r, g, b, hs, vs, de, got, ckp);
      chk(got == exp, {"R6 slot layout ", tag}, 64'(got), 64'(exp));
      chk(ckp == 7'b1100011, {"R7 clock lane ", tag}, 64'(ckp), 64'h63);
   endtask

   task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a < 3'd7) begin
         for (int f = 0; f < 4; f++) exp_sel[a*4+f] = int'(d[f*8 +: 5]);
      end
   endtask

   task automatic read_check(input logic [2:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      cfg_addr = a;
      #1;
      chk(cfg_rdata == exp, req, 64'(cfg_rdata), 64'(exp));
   endtask

   task automatic test_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      foreach (exp_sel[k]) exp_sel[k] = vesa_tab[k];
      #1;
      chk(lane_data == 4'h0, "R1 lanes low after reset", 64'(lane_data), 64'h0);
      chk(lane_clk == 1'b0, "R1 clock lane low after reset", 64'(lane_clk), 64'h0);
      chk(pix_load == 1'b0, "R9 no load with enable low", 64'(pix_load), 64'h0);
      bit_en = 1'b1; #1;
      chk(pix_load == 1'b1, "R9 first enabled edge samples", 64'(pix_load), 64'h1);
      bit_en = 1'b0;
      for (int w = 0; w < 7; w++) read_check(3'(w), pack_word(w), "R1 R3 reset select word");
   endtask

   task automatic test_vesa_default;
      pixel_check("vesa walk", 8'h01, 8'h80, 8'h55, 1'b1, 1'b0, 1'b1);
      pixel_check("vesa mix", 8'hC3, 8'h3C, 8'hA5, 1'b0, 1'b1, 1'b0);
      pixel_check("vesa ones", 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1);
   endtask

   task automatic test_bad_addr;
      cfg_write(3'd7, 32'h0000_0000);
      for (int w = 0; w < 7; w++) read_check(3'(w), pack_word(w), "R4 select word unchanged");
      read_check(3'd7, 32'h0, "R4 address 7 reads zero");
      pixel_check("after bad write R4", 8'h5A, 8'h0F, 8'hF0, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic test_gap;
      logic [27:0] got, exp;
      logic [3:0]  hold_d;
      logic        hold_c;
      exp = exp_slots(8'h96, 8'h69, 8'h3A, 1'b0, 1'b1, 1'b1);
      @(negedge clk);
      pix_r = 8'h96; pix_g = 8'h69; pix_b = 8'h3A; pix_hs = 1'b0; pix_vs = 1'b1; pix_de = 1'b1;
      bit_en = 1'b1; #1;
      while (!pix_load) begin @(negedge clk); #1; end
      @(negedge clk); #1;
      for (int l = 0; l < 4; l++) got[l*7] = lane_data[l];
      hold_d = lane_data; hold_c = lane_clk;
      bit_en = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); #1;
         chk(lane_data == hold_d && lane_clk == hold_c && !pix_load, "R8 hold while paused",
             64'({lane_clk, lane_data}), 64'({hold_c, hold_d}));
      end
      bit_en = 1'b1;
      for (int p = 1; p < 7; p++) begin
         @(negedge clk); #1;
         for (int l = 0; l < 4; l++) got[l*7+p] = lane_data[l];
      end
      bit_en = 1'b0;
      chk(got == exp, "R6 R8 pixel intact across pause", 64'(got), 64'(exp));
   endtask

   task automatic test_inflight_write;
      logic [27:0] got, exp_old;
      logic [31:0] nw;
      nw = {3'b0, 5'd0, 3'b0, 5'd24, 3'b0, 5'd25, 3'b0, 5'd26};
      exp_old = exp_slots(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      pix_r = 8'h00; pix_g = 8'h00; pix_b = 8'h00; pix_hs = 1'b1; pix_vs = 1'b0; pix_de = 1'b0;
      bit_en = 1'b1; #1;
      while (!pix_load) begin @(negedge clk); #1; end
      for (int p = 0; p < 7; p++) begin
         @(negedge clk); #1;
         for (int l = 0; l < 4; l++) got[l*7+p] = lane_data[l];
         if (p == 0) begin cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = nw; end
         else cfg_we = 1'b0;
      end
      bit_en = 1'b0;
      chk(got == exp_old, "R10 sampled pixel keeps old selects", 64'(got), 64'(exp_old));
      for (int f = 0; f < 4; f++) exp_sel[24+f] = int'(nw[f*8 +: 5]);
      pixel_check("R10 new selects next pixel", 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
      pixel_check("R10 new selects de", 8'h01, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
   endtask

   task automatic test_reserved;
      logic [27:0] got;
      logic [6:0]  ckp;
      cfg_write(3'd0, 32'hFFFF_FFFF);
      read_check(3'd0, 32'h1F1F_1F1F, "R3 reserved bits read zero");
      send_pixel(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, got, ckp);
      chk(got[3:0] == 4'h0, "R5 code 31 drives low", 64'(got[3:0]), 64'h0);
      chk(got[23] == 1'b0, "R5 code 27 drives low in slot 23", 64'(got[23]), 64'h0);
      chk(got[22:4] == 19'h7FFFF, "R6 other slots follow all-ones input", 64'(got[22:4]), 64'h7FFFF);
      cfg_write(3'd0, {3'b0, 5'd28, 3'b0, 5'd29, 3'b0, 5'd30, 3'b0, 5'd27});
      send_pixel(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, got, ckp);
      chk(got[3:0] == 4'h0, "R5 codes 27..30 drive low", 64'(got[3:0]), 64'h0);
   endtask

   task automatic test_identity;
      logic [27:0] got, exp;
      logic [6:0]  ckp;
      logic [7:0]  r, g, b;
      for (int w = 0; w < 7; w++)
         cfg_write(3'(w), {3'b0, 5'(4*w+3), 3'b0, 5'(4*w+2), 3'b0, 5'(4*w+1), 3'b0, 5'(4*w)});
      for (int i = 0; i < 4; i++) begin
         r = 8'h01 << i; g = 8'h80 >> i; b = 8'hA5 ^ 8'(i * 17);
         send_pixel(r, g, b, i[0], i[1], ~i[0], got, ckp);
         exp = {1'b0, ~i[0], i[1], i[0], b, g, r};
         chk(got == exp, "R2 identity map shows source codes", 64'(got), 64'(exp));
      end
   endtask

   task automatic test_jeida;
      for (int w = 0; w < 7; w++) begin
         logic [31:0] d = '0;
         for (int f = 0; f < 4; f++) d[f*8 +: 5] = 5'(jeida_tab[w*4+f]);
         cfg_write(3'(w), d);
      end
      for (int w = 0; w < 7; w++) read_check(3'(w), pack_word(w), "R3 jeida readback");
      pixel_check("jeida a", 8'h3C, 8'h81, 8'h7E, 1'b1, 1'b0, 1'b1);
      pixel_check("jeida b", 8'h01, 8'h02, 8'h04, 1'b0, 1'b0, 1'b1);
   endtask

   initial begin
      test_reset();
      test_vesa_default();
      test_bad_addr();
      test_gap();
      test_inflight_write();
      test_reserved();
      test_identity();
      test_jeida();
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R9 watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule